// File: doc/BRIEF.md
# CMOS RAM index/data port decoder

This block sits on a byte-wide I/O bus and turns accesses at three index/data port pairs into accesses to a 256-byte battery-backed CMOS array, which also holds the RTC registers. The block keeps one index latch per pair. A data-port access is then forwarded to the latched location, either on the internal array port or on an external RTC bus. The first index port also holds the NMI mask bit, so the block produces the gated NMI line from the two system error sources.

The legacy pair has a 7-bit index and reaches only the lower half of the array. The full pair has an 8-bit index and reaches the whole array. Both of these pairs go to the internal array when the internal-RTC select is high, and to the external RTC bus when it is low. The auxiliary pair also has an 8-bit index and always reaches the internal array. It responds only when both the internal-SRAM enable and the auxiliary-port enable are set.

Top module: `cmos_port_decoder`

## Requirements
- R1: After a synchronous reset, the NMI mask is 1, all three index latches are 0 and `nmi_out` is 0.
- R2: A write to the legacy index port (offset 0) stores data bit 7 as the NMI mask and bits 6:0 as the index. A read of that port returns `{mask, index}`.
- R3: A legacy data port access (offset 1) addresses `{1'b0, index[6:0]}`, so it never reaches the upper 128 bytes.
- R4: The full pair (index at offset 2, data at offset 3) addresses all 256 bytes with its 8-bit index, and its index reads back unchanged.
- R5: The auxiliary pair (index at offset 4, data at offset 5) is claimed only when `cfg_sram_en` and `cfg_aux_en` are both 1. Otherwise its reads return 0xFF and its index writes are ignored. When enabled it always reaches the internal array.
- R6: When `cfg_rtc_int` is 0, data accesses on the legacy and full pairs drive the external bus (`ext_re`/`ext_we`, `ext_addr`) and never the internal array strobes.
- R7: A data-port read returns the addressed byte in the same cycle. A data-port write raises the write strobe with `io_wdata` at the latched index.
- R8: `nmi_out` equals (`err_chan_chk` OR `err_sys_err`) AND NOT mask.
- R9: An index-port write raises neither `ram_we` nor `ext_we`, so it changes no stored byte.
- R10: Accesses outside offsets 0 to 5 of the `BASE` window are not claimed, and their reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, 0xFF when not claimed |
| io_claim | output | 1 | Address decoded by an enabled pair |
| cfg_rtc_int | input | 1 | Legacy/full pairs use internal array |
| cfg_sram_en | input | 1 | Internal SRAM enable |
| cfg_aux_en | input | 1 | Auxiliary pair enable |
| err_chan_chk | input | 1 | ISA channel-check event |
| err_sys_err | input | 1 | PCI system-error event |
| nmi_mask | output | 1 | Current NMI mask bit |
| nmi_out | output | 1 | Gated NMI request |
| ram_addr | output | 8 | Internal array address |
| ram_wdata | output | 8 | Internal array write data |
| ram_re | output | 1 | Internal array read strobe |
| ram_we | output | 1 | Internal array write strobe |
| ram_rdata | input | 8 | Internal array read data |
| ext_addr | output | 8 | External RTC address |
| ext_wdata | output | 8 | External RTC write data |
| ext_re | output | 1 | External RTC read strobe |
| ext_we | output | 1 | External RTC write strobe |
| ext_rdata | input | 8 | External RTC read data |

## Verification
The bench gives the internal array and the external bus different fill patterns, so every read result shows which target was reached and at which address. Index values above 0x7F are used on the legacy port and then read through the full pair: this separates 7-bit reach from 8-bit reach. The auxiliary pair is tried with no enable, with one enable and with both enables. Reading the index back after each case shows whether a write that should be ignored was dropped. Writes made while the select is low are read back after the select is raised, which shows that the internal array was left alone.

// File: rtl/cmos_dec_pkg.sv
// Shared types for the CMOS port decoder.
// Assumes at most one of io_rd / io_wr is high in a cycle.
package cmos_dec_pkg;
    typedef enum logic [1:0] {
        PAIR_LEGACY = 2'd0,
        PAIR_FULL   = 2'd1,
        PAIR_AUX    = 2'd2,
        PAIR_NONE   = 2'd3
    } pair_e;
endpackage

// File: rtl/cmos_addr_decode.sv
// Maps an I/O address onto a port pair and an index/data role.
// Assumes that the pairs sit back to back from BASE, index port first.
module cmos_addr_decode
    import cmos_dec_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0070,
    parameter int          NPAIR  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output pair_e             pair,
    output logic              is_data
);
    localparam int SPAN = 2 * NPAIR;

    logic [NPAIR-1:0] pair_hit;
    logic [ADDR_W-1:0] offs;

    assign offs = addr - ADDR_W'(BASE);

    // One comparator for each pair.
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair_hit[g] = (offs >= ADDR_W'(2*g)) && (offs < ADDR_W'(2*g+2));
    end

    // Turn the hit vector into a pair code.
    always_comb begin
        pair = PAIR_NONE;
        for (int i = 0; i < NPAIR; i++) begin
            if (pair_hit[i]) pair = pair_e'(i);
        end
    end

    assign is_data = (offs < ADDR_W'(SPAN)) && offs[0];
endmodule

// File: rtl/cmos_index_regs.sv
// Holds the three index latches and the NMI mask bit.
// Assumes wr_en is already limited to claimed index-port writes.
module cmos_index_regs
    import cmos_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  pair_e             pair,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-2:0] idx_legacy,
    output logic              mask,
    output logic [DATA_W-1:0] idx_full,
    output logic [DATA_W-1:0] idx_aux
);
    // Latch the index, and the mask on the legacy port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_legacy <= '0;
            mask       <= 1'b1;
            idx_full   <= '0;
            idx_aux    <= '0;
        end else if (wr_en) begin
            case (pair)
                PAIR_LEGACY: begin
                    mask       <= wdata[DATA_W-1];
                    idx_legacy <= wdata[DATA_W-2:0];
                end
                PAIR_FULL: idx_full <= wdata;
                PAIR_AUX:  idx_aux  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmos_route.sv
// Steers a data access to the internal array or the external RTC bus,
// and builds the read data. Purely combinational.
module cmos_route
    import cmos_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  pair_e             pair,
    input  logic              is_data,
    input  logic              claim,
    input  logic              rd,
    input  logic              wr,
    input  logic              rtc_int,
    input  logic [DATA_W-2:0] idx_legacy,
    input  logic              mask,
    input  logic [DATA_W-1:0] idx_full,
    input  logic [DATA_W-1:0] idx_aux,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] tgt_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic              ext_re,
    output logic              ext_we,
    output logic [DATA_W-1:0] rdata
);
    logic internal;
    logic [DATA_W-1:0] idx_view;
    logic dacc;

    assign internal = (pair == PAIR_AUX) || rtc_int;
    assign dacc     = claim && is_data;

    // Effective target address and index read-back value for each pair.
    always_comb begin
        case (pair)
            PAIR_LEGACY: begin
                tgt_addr = {1'b0, idx_legacy};
                idx_view = {mask, idx_legacy};
            end
            PAIR_FULL: begin
                tgt_addr = idx_full;
                idx_view = idx_full;
            end
            default: begin
                tgt_addr = idx_aux;
                idx_view = idx_aux;
            end
        endcase
    end

    assign ram_re = dacc && rd && internal;
    assign ram_we = dacc && wr && internal;
    assign ext_re = dacc && rd && !internal;
    assign ext_we = dacc && wr && !internal;

    // Read mux: idle value when nothing is claimed.
    always_comb begin
        if (!(claim && rd))  rdata = '1;
        else if (!is_data)   rdata = idx_view;
        else if (internal)   rdata = ram_rdata;
        else                 rdata = ext_rdata;
    end
endmodule

// File: rtl/cmos_port_decoder.sv
// Top: CMOS index/data port decoder with NMI mask.
// Assumes a single-cycle I/O access with io_rd and io_wr never both high.
module cmos_port_decoder
    import cmos_dec_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 8,
    parameter logic [15:0] BASE   = 16'h0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_claim,
    input  logic              cfg_rtc_int,
    input  logic              cfg_sram_en,
    input  logic              cfg_aux_en,
    input  logic              err_chan_chk,
    input  logic              err_sys_err,
    output logic              nmi_mask,
    output logic              nmi_out,
    output logic [DATA_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_re,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_re,
    output logic              ext_we,
    input  logic [DATA_W-1:0] ext_rdata
);
    localparam int NPAIR = 3;

    pair_e pair;
    logic is_data, pair_ok, idx_wr;
    logic [DATA_W-2:0] idx_legacy;
    logic [DATA_W-1:0] idx_full, idx_aux, tgt_addr;

    cmos_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NPAIR(NPAIR)) u_dec (
        .addr(io_addr), .pair(pair), .is_data(is_data)
    );

    // The auxiliary pair needs both enables; the others are always present.
    assign pair_ok  = (pair == PAIR_AUX) ? (cfg_sram_en && cfg_aux_en) : (pair != PAIR_NONE);
    assign io_claim = pair_ok;
    assign idx_wr   = io_claim && io_wr && !is_data;

    cmos_index_regs #(.DATA_W(DATA_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .wr_en(idx_wr), .pair(pair), .wdata(io_wdata),
        .idx_legacy(idx_legacy), .mask(nmi_mask), .idx_full(idx_full), .idx_aux(idx_aux)
    );

    cmos_route #(.DATA_W(DATA_W)) u_route (
        .pair(pair), .is_data(is_data), .claim(io_claim), .rd(io_rd), .wr(io_wr),
        .rtc_int(cfg_rtc_int), .idx_legacy(idx_legacy), .mask(nmi_mask),
        .idx_full(idx_full), .idx_aux(idx_aux), .ram_rdata(ram_rdata),
        .ext_rdata(ext_rdata), .tgt_addr(tgt_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ext_re(ext_re), .ext_we(ext_we), .rdata(io_rdata)
    );

    assign ram_addr  = tgt_addr;
    assign ext_addr  = tgt_addr;
    assign ram_wdata = io_wdata;
    assign ext_wdata = io_wdata;

    // Either error source raises NMI unless it is masked.
    assign nmi_out = (err_chan_chk || err_sys_err) && !nmi_mask;
endmodule

// File: rtl/cmos_port_decoder_chk.sv
// Checker for cmos_port_decoder, attached with bind.
module cmos_port_decoder_chk #(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0070
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              io_claim,
    input logic              cfg_rtc_int,
    input logic              nmi_mask,
    input logic              nmi_out,
    input logic [7:0]        ram_addr,
    input logic              ram_we,
    input logic              ext_we
);
    logic at_leg_idx, at_leg_dat, at_aux_dat, at_idx;
    assign at_leg_idx = io_addr == ADDR_W'(BASE);
    assign at_leg_dat = io_addr == ADDR_W'(BASE) + ADDR_W'(1);
    assign at_aux_dat = io_addr == ADDR_W'(BASE) + ADDR_W'(5);
    assign at_idx     = at_leg_idx || (io_addr == ADDR_W'(BASE) + ADDR_W'(2))
                        || (io_addr == ADDR_W'(BASE) + ADDR_W'(4));

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |-> !nmi_mask); // R8
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_leg_idx) |=> $stable(nmi_mask)); // R2
    AST_LEGACY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (at_leg_dat && ram_we) |-> !ram_addr[7]); // R3
    AST_UNCLAIMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_claim |-> (io_rdata == 8'hFF)); // R10
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ext_we)); // R6
    AST_EXT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cfg_rtc_int || at_aux_dat)); // R6
    AST_INDEX_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_idx) |-> !(ram_we || ext_we)); // R9
endmodule

bind cmos_port_decoder cmos_port_decoder_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rdata(io_rdata),
    .io_claim(io_claim), .cfg_rtc_int(cfg_rtc_int), .nmi_mask(nmi_mask),
    .nmi_out(nmi_out), .ram_addr(ram_addr), .ram_we(ram_we), .ext_we(ext_we)
);

// File: tb/cmos_port_decoder_tb.sv
// Scoreboard bench: read tasks queue expectations, a monitor compares them.
module cmos_port_decoder_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    logic [15:0] io_addr = 0;
    logic [7:0]  io_wdata = 0;
    logic io_rd = 0, io_wr = 0;
    logic [7:0] io_rdata;
    logic io_claim;
    logic cfg_rtc_int = 1, cfg_sram_en = 0, cfg_aux_en = 0;
    logic err_chan_chk = 0, err_sys_err = 0;
    logic nmi_mask, nmi_out;
    logic [7:0] ram_addr, ram_wdata, ram_rdata, ext_addr, ext_wdata, ext_rdata;
    logic ram_re, ram_we, ext_re, ext_we;

    logic [7:0] ram_mem [256];
    logic [7:0] ext_mem [256];
    logic [7:0] exp_d [$];
    logic       exp_c [$];
    string      exp_t [$];
    int n_cmp = 0, n_bad = 0;
    logic done = 0;

    always #5 clk = ~clk;

    cmos_port_decoder dut_i (.*);

    assign ram_rdata = ram_mem[ram_addr];
    assign ext_rdata = ext_mem[ext_addr];

    // Memory models behind the two target buses.
    always @(posedge clk) begin
        if (ram_we) ram_mem[ram_addr] <= ram_wdata;
        if (ext_we) ext_mem[ext_addr] <= ext_wdata;
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expectation per read cycle.
    always @(negedge clk) begin
        if (io_rd && exp_d.size() > 0) begin
            chk({exp_t[0], " data"}, io_rdata, exp_d.pop_front());
            chk({exp_t.pop_front(), " claim"}, {7'd0, io_claim}, {7'd0, exp_c.pop_front()});
        end
    end

    task automatic wr(logic [2:0] off, logic [7:0] d);
        @(posedge clk); #1;
        io_addr = 16'h0070 + 16'(off); io_wdata = d; io_wr = 1;
        @(posedge clk); #1;
        io_wr = 0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, logic c, string tag);
        exp_d.push_back(exp); exp_c.push_back(c); exp_t.push_back(tag);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1;
        @(posedge clk); #1;
        io_rd = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram_mem[i] = 8'(i);
            ext_mem[i] = 8'(i) ^ 8'hC3;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        chk("R1 mask", {7'd0, nmi_mask}, 8'h01);
        err_chan_chk = 1; #1;
        chk("R1 nmi masked", {7'd0, nmi_out}, 8'h00);
        rd(16'h0070, 8'h80, 1, "R1 legacy index");
        rd(16'h0072, 8'h00, 1, "R1 full index");
        // NMI gating
        wr(0, 8'h05);
        chk("R8 chan chk", {7'd0, nmi_out}, 8'h01);
        err_chan_chk = 0; err_sys_err = 1; #1;
        chk("R8 sys err", {7'd0, nmi_out}, 8'h01);
        err_sys_err = 0; #1;
        chk("R8 idle", {7'd0, nmi_out}, 8'h00);
        rd(16'h0070, 8'h05, 1, "R2 index readback");
        wr(0, 8'hC5);
        rd(16'h0070, 8'hC5, 1, "R2 mask+index");
        err_sys_err = 1; #1;
        chk("R8 remasked", {7'd0, nmi_out}, 8'h00);
        err_sys_err = 0;
        // Legacy data port, 7-bit reach
        wr(1, 8'h3C);
        rd(16'h0071, 8'h3C, 1, "R7 legacy data");
        wr(2, 8'h45);
        rd(16'h0073, 8'h3C, 1, "R3 lower half hit");
        wr(2, 8'hC5);
        rd(16'h0073, 8'hC5, 1, "R3 upper half untouched");
        wr(3, 8'hA7);
        rd(16'h0072, 8'hC5, 1, "R4 full index");
        rd(16'h0073, 8'hA7, 1, "R4 upper byte");
        wr(0, 8'h7F);
        rd(16'h0071, 8'h7F, 1, "R3 top of lower half");
        wr(2, 8'hC5);
        rd(16'h0073, 8'hA7, 1, "R9 index write no store");
        // Auxiliary pair gating
        rd(16'h0074, 8'hFF, 0, "R5 aux off");
        wr(4, 8'h10);
        cfg_sram_en = 1;
        rd(16'h0075, 8'hFF, 0, "R5 one enable");
        wr(4, 8'h11);
        cfg_aux_en = 1;
        rd(16'h0074, 8'h00, 1, "R5 ignored index");
        wr(4, 8'h20);
        cfg_rtc_int = 0;
        wr(5, 8'h99);
        cfg_rtc_int = 1;
        wr(2, 8'h20);
        rd(16'h0073, 8'h99, 1, "R5 aux reaches internal");
        // External routing
        cfg_rtc_int = 0;
        wr(0, 8'h45);
        rd(16'h0071, 8'h45 ^ 8'hC3, 1, "R6 ext read");
        wr(1, 8'h11);
        rd(16'h0071, 8'h11, 1, "R6 ext write");
        wr(2, 8'hE0);
        rd(16'h0073, 8'hE0 ^ 8'hC3, 1, "R6 full ext");
        cfg_rtc_int = 1;
        rd(16'h0071, 8'h3C, 1, "R6 internal untouched");
        // Out of window
        rd(16'h0076, 8'hFF, 0, "R10 offset 6");
        rd(16'h0080, 8'hFF, 0, "R10 far address");
        repeat (2) @(posedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule